// File: doc/BRIEF.md
# Rotation Period Capture Peripheral

This block is a memory-mapped APB3 slave that measures the time between successive pulses from a rotating cup wind sensor. A free-running counter advances once per bus clock. Each rising edge of the sensor input copies the number of clocks since the previous edge into a period register. The same edge restarts the counter from zero and flags the event to software through a level-sensitive interrupt.

The count is taken in hardware at the moment the edge is detected. Interrupt latency and software delay therefore add no error to the measured period. Software reads the period and the status word, then acknowledges the event by writing 1 to the pending flag. The raw sensor signal is asynchronous, so it passes through a two-stage synchronizer before the rising-edge detector.

The register file is decoded on address bit 2. Offset 0x0 holds the period and is read-only. Offset 0x4 holds the status and control word: bit 0 is the interrupt enable (read/write), bit 1 is the pending flag (write 1 to clear), and bit 2 is the overrun flag (write 1 to clear). All other bits read as zero.

Top module: `rotperiod_apb`

## Requirements
- R1: After reset, offset 0x0 and offset 0x4 both read 0 and `irq` is low.
- R2: When two sensor rising edges are N clocks apart, the value read at offset 0x0 after the second edge is N.
- R3: Each detected rising edge sets the pending flag, bit 1 at offset 0x4.
- R4: `irq` is high exactly when the pending flag and the enable bit (bit 0 at offset 0x4) are both 1. The enable bit reads back the value last written to it.
- R5: Writing offset 0x4 with bit 1 set clears the pending flag. Writing with bit 1 clear leaves the pending flag unchanged.
- R6: An edge that arrives while the pending flag is set overwrites the period register and sets the overrun flag, bit 2 at offset 0x4. Writing 1 to bit 2 clears the overrun flag and does not affect the pending flag.
- R7: Writes to offset 0x0 have no effect on the period register.
- R8: A sensor level held high produces only one capture. Only the rising edge triggers a capture.
- R9: `pready` is high during every access phase, so every transfer completes with zero wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address; bit 2 selects the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready, always high |
| sensor_in | input | 1 | Asynchronous rotation pulse |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The bench uses three different edge spacings: 50, 137 and 7 clocks. A period register that is off by one, stale, or cleared at the wrong moment gives a wrong value for at least one of them. A pulse train is compared against a level held high for hundreds of clocks, which separates edge triggering from level triggering. Back-to-back edges without an acknowledge exercise overrun. Writes that set and clear individual status bits show that each bit clears only when its own bit is written as 1.

// File: rtl/rotperiod_apb.sv
`timescale 1ns/1ps
module rotperiod_apb #(
  parameter int TW = 32,
  parameter int AW = 8
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  input  logic          sensor_in,
  output logic          irq
);
  localparam int SEL_BIT = 2;

  logic          s1, s2, s3;
  logic          cap_edge;
  logic [TW-1:0] timer, cap;
  logic          ien, pend, ovr;
  logic          ctrl_wr;

  assign cap_edge = s2 & ~s3;
  assign ctrl_wr  = psel & penable & pwrite & paddr[SEL_BIT];
  assign pready   = 1'b1;
  assign irq      = pend & ien;
  assign prdata   = paddr[SEL_BIT] ? {29'b0, ovr, pend, ien} : 32'(cap);

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= sensor_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      timer <= '0;
      cap   <= '0;
    end else if (cap_edge) begin
      timer <= '0;
      cap   <= timer + TW'(1);
    end else begin
      timer <= timer + TW'(1);
    end
  end

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      ien  <= 1'b0;
      pend <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ien <= pwdata[0];
        if (pwdata[1]) pend <= 1'b0;
        if (pwdata[2]) ovr  <= 1'b0;
      end
      if (cap_edge) begin
        pend <= 1'b1;
        if (pend) ovr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rotperiod_apb_chk.sv
`timescale 1ns/1ps
module rotperiod_apb_chk #(
  parameter int TW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_edge,
  input logic [TW-1:0] timer,
  input logic [TW-1:0] cap,
  input logic          pend,
  input logic          ovr,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [31:0]   pwdata
);
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_edge |=> timer == '0);
  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_edge |=> timer == $past(timer) + TW'(1));
  p_set_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_edge |=> pend);
  p_clear_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr[2] && pwdata[1] && !cap_edge) |=> !pend);
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_edge && pend) |=> ovr);
  p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_edge |=> $stable(cap));
endmodule

bind rotperiod_apb rotperiod_apb_chk #(.TW(TW), .AW(AW)) u_chk (
  .clk(pclk), .rst_n(presetn), .cap_edge(cap_edge), .timer(timer), .cap(cap),
  .pend(pend), .ovr(ovr), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata)
);

// File: tb/rotperiod_apb_tb.sv
`timescale 1ns/1ps
module rotperiod_apb_tb;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, irq;
  logic        sensor_in = 1'b0;

  int checks = 0, fails = 0, cyc = 0, last_rise = 0;
  logic [31:0] rd;

  rotperiod_apb u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .sensor_in(sensor_in), .irq(irq)
  );

  always #2.5 pclk = ~pclk;
  always @(posedge pclk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_write(logic [7:0] a, logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    check("R9", {31'b0, pready}, 32'd1);
    d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge pclk);
  endtask

  task automatic pulse_at(int t);
    wait_to(t);
    sensor_in = 1'b1;
    last_rise = cyc;
    repeat (3) @(negedge pclk);
    sensor_in = 1'b0;
  endtask

  task automatic t_reset;
    apb_read(8'h00, rd); check("R1 period", rd, 32'd0);
    apb_read(8'h04, rd); check("R1 status", rd, 32'd0);
    check("R1 irq", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_periods;
    pulse_at(cyc + 2);
    apb_write(8'h04, 32'h7);
    pulse_at(last_rise + 50);
    wait_to(last_rise + 5);
    apb_read(8'h00, rd); check("R2 period 50", rd, 32'd50);
    apb_read(8'h04, rd); check("R3 pending", rd & 32'h2, 32'h2);
    apb_write(8'h04, 32'h7);
    pulse_at(last_rise + 137);
    wait_to(last_rise + 5);
    apb_read(8'h00, rd); check("R2 period 137", rd, 32'd137);
    apb_write(8'h04, 32'h7);
    pulse_at(last_rise + 7);
    pulse_at(last_rise + 7);
    wait_to(last_rise + 5);
    apb_read(8'h00, rd); check("R2 period 7", rd, 32'd7);
    apb_write(8'h04, 32'h7);
  endtask

  task automatic t_irq;
    apb_write(8'h04, 32'h0);
    pulse_at(cyc + 2);
    wait_to(last_rise + 5);
    check("R4 irq masked", {31'b0, irq}, 32'd0);
    apb_write(8'h04, 32'h1);
    apb_read(8'h04, rd); check("R4 enable readback", rd, 32'h3);
    check("R4 irq raised", {31'b0, irq}, 32'd1);
    apb_write(8'h04, 32'h1);
    apb_read(8'h04, rd); check("R5 write0 keeps pending", rd, 32'h3);
    apb_write(8'h04, 32'h3);
    apb_read(8'h04, rd); check("R5 cleared", rd, 32'h1);
    check("R5 irq low", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_overrun;
    pulse_at(cyc + 2);
    pulse_at(last_rise + 40);
    wait_to(last_rise + 5);
    apb_read(8'h04, rd); check("R6 overrun set", rd, 32'h7);
    apb_read(8'h00, rd); check("R6 overwritten", rd, 32'd40);
    apb_write(8'h04, 32'h5);
    apb_read(8'h04, rd); check("R6 ovr cleared pend kept", rd, 32'h3);
    apb_write(8'h04, 32'h3);
  endtask

  task automatic t_ro_period;
    apb_read(8'h00, rd);
    apb_write(8'h00, 32'hDEADBEEF);
    apb_read(8'h00, rd); check("R7 period unchanged", rd, 32'd40);
  endtask

  task automatic t_level;
    wait_to(cyc + 2);
    sensor_in = 1'b1;
    last_rise = cyc;
    wait_to(last_rise + 5);
    apb_write(8'h04, 32'h3);
    wait_to(last_rise + 300);
    apb_read(8'h04, rd); check("R8 single capture", rd, 32'h1);
    sensor_in = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    t_reset();
    t_periods();
    t_irq();
    t_overrun();
    t_ro_period();
    t_level();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule